// File: doc/BRIEF.md
# CAN Receive Record Buffer

This block holds received CAN frames in a 64-byte circular store, each frame packed as a record whose length depends on its format. The write side accepts one complete frame in a single cycle and serialises it into record bytes. A frame carries an extended-format flag, a remote-request flag, a length code, an identifier and up to eight data bytes. A frame that no longer fits in the free space is dropped whole, and a sticky overrun flag is raised.

The read side shows a 13-byte window that begins at the oldest stored record. A host register interface reads any byte of that record by offset. A release command drops the oldest record. To find how far to move the read start, it decodes that record's length from its first byte. The block also reports a byte count, a message count and a non-empty flag.

Top module: `canrx_rec_fifo`

## Requirements
- R1: The first byte of every record is an information byte: bit 7 = extended flag, bit 6 = remote flag, bits 5:4 = 0, bits 3:0 = stored length code.
- R2: An extended record is: info, ID[28:21], ID[20:13], ID[12:5], {ID[4:0], 3'b000}, then the data bytes (data byte 0 first, taken from wr_data[7:0]).
- R3: A standard record is: info, ID[10:3], {ID[2:0], 5'b00000}, then the data bytes.
- R4: A record occupies 3 bytes (standard) or 5 bytes (extended) plus its data byte count. A remote frame stores no data bytes but keeps its length code in the info byte. An accepted frame adds its record length to byte_cnt and one to msg_cnt.
- R5: A length code above 8 is stored as 8 in the info byte, and 8 data bytes are stored.
- R6: If byte_cnt plus the new record length exceeds 64, the frame is discarded: stored bytes, byte_cnt and msg_cnt are unchanged, and ovr_flag is set. A record that fills the store exactly is accepted.
- R7: A release with msg_cnt > 0 moves the read start by the head record's length modulo 64, subtracts that length from byte_cnt and one from msg_cnt. nonempty is 1 exactly when msg_cnt is non-zero.
- R8: A release when msg_cnt is 0 changes nothing.
- R9: rd_byte at offset k (0 to 12) is the stored byte at (start + k) mod 64. Offsets 13 to 15 read 0.
- R10: clr_ovr clears ovr_flag. If a frame is dropped in the same cycle, the flag is set instead.
- R11: A write and a release in the same cycle both take effect. The fit test uses byte_cnt from before the release.
- R12: Reset clears both pointers, both counts, ovr_flag and nonempty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | One-cycle strobe: store the presented frame |
| wr_ext | input | 1 | Frame uses the 29-bit identifier |
| wr_rtr | input | 1 | Frame is a remote request |
| wr_dlc | input | 4 | Length code of the frame |
| wr_id | input | 29 | Identifier (standard frames use bits 10:0) |
| wr_data | input | 64 | Data bytes, byte i in bits 8i+7:8i |
| rel_cmd | input | 1 | One-cycle strobe: discard the oldest record |
| clr_ovr | input | 1 | One-cycle strobe: clear the overrun flag |
| rd_off | input | 4 | Byte offset into the head record window |
| rd_byte | output | 8 | Byte at the window offset (combinational) |
| byte_cnt | output | 7 | Bytes occupied by stored records |
| msg_cnt | output | 5 | Number of stored records |
| ovr_flag | output | 1 | Sticky: a frame was dropped for lack of space |
| nonempty | output | 1 | At least one record is stored |

## Verification
The assertions assume each strobe stands for one event per cycle held high, and that a frame's fields are stable while wr_valid is high. They also assume the store depth is a power of two, so pointer wrap is plain binary rollover. The stimulus drives every strobe for exactly one cycle from the falling edge, and clears it on the next falling edge. It leaves the default depth in place, so every pointer sum in the design wraps the same way as the bench's modulo-64 model.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

  localparam int unsigned HDR_STD  = 3;
  localparam int unsigned HDR_EXT  = 5;
  localparam int unsigned DATA_MAX = 8;
  localparam int unsigned REC_MAX  = HDR_EXT + DATA_MAX;

  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [3:0]  dlc;
    logic [28:0] id;
    logic [63:0] data;
  } frame_t;

  // Record length encoded by an information byte.
  function automatic logic [3:0] rec_len(input byte_t info);
    logic [3:0] ndata;
    logic [3:0] hdr;
    ndata = (info[3:0] > 4'(DATA_MAX)) ? 4'(DATA_MAX) : info[3:0];
    if (info[6]) ndata = 4'd0;
    hdr = info[7] ? 4'(HDR_EXT) : 4'(HDR_STD);
    return hdr + ndata;
  endfunction

endpackage

// File: rtl/canrx_rec_pack.sv
module canrx_rec_pack
  import canrx_pkg::*;
(
  input  frame_t                          frm_i,
  output logic [REC_MAX-1:0][7:0]         rec_o,
  output logic [3:0]                      len_o
);

  logic [3:0] code_clamped;
  logic [3:0] ndata;
  byte_t      info;

  always_comb begin
    code_clamped = (frm_i.dlc > 4'(DATA_MAX)) ? 4'(DATA_MAX) : frm_i.dlc;
    ndata        = frm_i.rtr ? 4'd0 : code_clamped;
    info         = {frm_i.ext, frm_i.rtr, 2'b00, code_clamped};
    len_o        = rec_len(info);
  end

  always_comb begin
    rec_o    = '0;
    rec_o[0] = info;
    if (frm_i.ext) begin
      rec_o[1] = frm_i.id[28:21];
      rec_o[2] = frm_i.id[20:13];
      rec_o[3] = frm_i.id[12:5];
      rec_o[4] = {frm_i.id[4:0], 3'b000};
    end else begin
      rec_o[1] = frm_i.id[10:3];
      rec_o[2] = {frm_i.id[2:0], 5'b00000};
    end
    for (int i = 0; i < int'(DATA_MAX); i++) begin
      if (4'(i) < ndata) begin
        if (frm_i.ext) rec_o[HDR_EXT + i] = frm_i.data[8*i +: 8];
        else           rec_o[HDR_STD + i] = frm_i.data[8*i +: 8];
      end
    end
  end

endmodule

// File: rtl/canrx_rec_store.sv
module canrx_rec_store
  import canrx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
)(
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [AW-1:0]           wr_ptr_i,
  input  logic [3:0]              wr_len_i,
  input  logic [REC_MAX-1:0][7:0] rec_i,
  input  logic [AW-1:0]           rd_ptr_i,
  input  logic [3:0]              rd_off_i,
  output byte_t                   rd_byte_o,
  output byte_t                   head_byte_o
);

  byte_t             mem_q [DEPTH];
  logic [DEPTH-1:0]  hit;
  logic [AW-1:0]     offs [DEPTH];
  logic [AW-1:0]     rd_addr;

  // Each cell decides on its own whether it lies inside the new record.
  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cell
    always_comb begin
      offs[g] = AW'(g) - wr_ptr_i;
      hit[g]  = we_i && (offs[g] < AW'(wr_len_i));
    end
  end

  // Storage: no reset, enabled per cell.
  always_ff @(posedge clk) begin
    for (int g = 0; g < int'(DEPTH); g++) begin
      if (hit[g]) mem_q[g] <= rec_i[offs[g][3:0]];
    end
  end

  always_comb begin
    rd_addr     = rd_ptr_i + AW'(rd_off_i);
    rd_byte_o   = (rd_off_i < 4'(REC_MAX)) ? mem_q[rd_addr] : 8'h00;
    head_byte_o = mem_q[rd_ptr_i];
  end

endmodule

// File: rtl/canrx_rec_ctrl.sv
module canrx_rec_ctrl
  import canrx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned MW   = $clog2(DEPTH / HDR_STD + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid_i,
  input  logic [3:0]    wr_len_i,
  input  logic          rel_cmd_i,
  input  logic          clr_ovr_i,
  input  byte_t         head_byte_i,
  output logic          we_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] byte_cnt_o,
  output logic [MW-1:0] msg_cnt_o,
  output logic          ovr_o,
  output logic          nonempty_o
);

  localparam logic [CW:0] CAP = (CW+1)'(DEPTH);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] byte_cnt_q, byte_cnt_d;
  logic [MW-1:0] msg_cnt_q, msg_cnt_d;
  logic          ovr_q, ovr_d;
  logic          ne_q, ne_d;

  logic          fits, accept, drop, rel_ok, upd_en;
  logic [3:0]    rel_len;
  logic [CW:0]   need;

  always_comb begin
    need    = {1'b0, byte_cnt_q} + (CW+1)'(wr_len_i);
    fits    = (need <= CAP);
    accept  = wr_valid_i && fits;
    drop    = wr_valid_i && !fits;
    rel_ok  = rel_cmd_i && (msg_cnt_q != '0);
    rel_len = rec_len(head_byte_i);
    upd_en  = accept || drop || rel_ok || clr_ovr_i;
  end

  always_comb begin
    wr_ptr_d   = wr_ptr_q;
    rd_ptr_d   = rd_ptr_q;
    byte_cnt_d = byte_cnt_q;
    msg_cnt_d  = msg_cnt_q;
    if (accept) begin
      wr_ptr_d   = wr_ptr_q + AW'(wr_len_i);
      byte_cnt_d = byte_cnt_d + CW'(wr_len_i);
      msg_cnt_d  = msg_cnt_d + MW'(1);
    end
    if (rel_ok) begin
      rd_ptr_d   = rd_ptr_q + AW'(rel_len);
      byte_cnt_d = byte_cnt_d - CW'(rel_len);
      msg_cnt_d  = msg_cnt_d - MW'(1);
    end
    if (drop)           ovr_d = 1'b1;
    else if (clr_ovr_i) ovr_d = 1'b0;
    else                ovr_d = ovr_q;
    ne_d = (msg_cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      byte_cnt_q <= '0;
      msg_cnt_q  <= '0;
      ovr_q      <= 1'b0;
      ne_q       <= 1'b0;
    end else if (upd_en) begin
      wr_ptr_q   <= wr_ptr_d;
      rd_ptr_q   <= rd_ptr_d;
      byte_cnt_q <= byte_cnt_d;
      msg_cnt_q  <= msg_cnt_d;
      ovr_q      <= ovr_d;
      ne_q       <= ne_d;
    end
  end

  assign we_o       = accept;
  assign wr_ptr_o   = wr_ptr_q;
  assign rd_ptr_o   = rd_ptr_q;
  assign byte_cnt_o = byte_cnt_q;
  assign msg_cnt_o  = msg_cnt_q;
  assign ovr_o      = ovr_q;
  assign nonempty_o = ne_q;

  // R4: packed record length always within header..header+data bounds
  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_i |-> (wr_len_i >= 4'(HDR_STD)) && (wr_len_i <= 4'(REC_MAX)));

  // R6: occupancy never exceeds capacity
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, byte_cnt_q} <= CAP);

  // R6: dropped frame leaves counts and write pointer untouched
  p_drop_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !fits && !rel_cmd_i) |=>
      ($stable(byte_cnt_q) && $stable(msg_cnt_q) && $stable(wr_ptr_q)));

  // R6: dropped frame raises overrun
  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !fits) |=> ovr_q);

  // R7: empty store holds no bytes
  p_empty_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_cnt_q == '0) |-> (byte_cnt_q == '0));

  // R7: non-empty flag tracks the message count
  p_ne_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ne_q == (msg_cnt_q != '0));

  // R8: release on empty store is ignored
  p_empty_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cmd_i && msg_cnt_q == '0 && !wr_valid_i) |=>
      ($stable(rd_ptr_q) && msg_cnt_q == '0));

  // R10: clear without a concurrent drop clears overrun
  p_clr_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr_i && !(wr_valid_i && !fits)) |=> !ovr_q);

  // R11: write pointer stays occupancy ahead of read pointer
  p_ptr_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr_q == rd_ptr_q + byte_cnt_q[AW-1:0]);

endmodule

// File: rtl/canrx_rec_fifo.sv
module canrx_rec_fifo
  import canrx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned MW   = $clog2(DEPTH / HDR_STD + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_ext,
  input  logic          wr_rtr,
  input  logic [3:0]    wr_dlc,
  input  logic [28:0]   wr_id,
  input  logic [63:0]   wr_data,
  input  logic          rel_cmd,
  input  logic          clr_ovr,
  input  logic [3:0]    rd_off,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] byte_cnt,
  output logic [MW-1:0] msg_cnt,
  output logic          ovr_flag,
  output logic          nonempty
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  frame_t                  frm;
  logic [REC_MAX-1:0][7:0] rec;
  logic [3:0]              rec_len_w;
  logic                    we;
  logic [AW-1:0]           wr_ptr, rd_ptr;
  byte_t                   head_byte;

  assign frm = '{ext: wr_ext, rtr: wr_rtr, dlc: wr_dlc, id: wr_id, data: wr_data};

  canrx_rec_pack u_pack (
    .frm_i (frm),
    .rec_o (rec),
    .len_o (rec_len_w)
  );

  canrx_rec_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .wr_valid_i  (wr_valid),
    .wr_len_i    (rec_len_w),
    .rel_cmd_i   (rel_cmd),
    .clr_ovr_i   (clr_ovr),
    .head_byte_i (head_byte),
    .we_o        (we),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .byte_cnt_o  (byte_cnt),
    .msg_cnt_o   (msg_cnt),
    .ovr_o       (ovr_flag),
    .nonempty_o  (nonempty)
  );

  canrx_rec_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .we_i        (we),
    .wr_ptr_i    (wr_ptr),
    .wr_len_i    (rec_len_w),
    .rec_i       (rec),
    .rd_ptr_i    (rd_ptr),
    .rd_off_i    (rd_off),
    .rd_byte_o   (rd_byte),
    .head_byte_o (head_byte)
  );

endmodule

// File: tb/canrx_rec_fifo_bench.sv
`timescale 1ns/1ps
module canrx_rec_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ext, wr_rtr, rel_cmd, clr_ovr;
  logic [3:0]  wr_dlc, rd_off;
  logic [28:0] wr_id;
  logic [63:0] wr_data;
  logic [7:0]  rd_byte;
  logic [6:0]  byte_cnt;
  logic [4:0]  msg_cnt;
  logic        ovr_flag, nonempty;

  always #2.5 clk = ~clk;

  canrx_rec_fifo u_canrx_rec_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ext(wr_ext),
    .wr_rtr(wr_rtr), .wr_dlc(wr_dlc), .wr_id(wr_id), .wr_data(wr_data),
    .rel_cmd(rel_cmd), .clr_ovr(clr_ovr), .rd_off(rd_off),
    .rd_byte(rd_byte), .byte_cnt(byte_cnt), .msg_cnt(msg_cnt),
    .ovr_flag(ovr_flag), .nonempty(nonempty)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model
  logic [7:0] mmem [64];
  int mrp, mwp, mbc, mmc;
  bit movr;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mmem[i] = 8'h00;
    mrp = 0; mwp = 0; mbc = 0; mmc = 0; movr = 1'b0;
  endtask

  task automatic model_step(input bit wv, input bit ext, input bit rtr,
                            input logic [3:0] dlc, input logic [28:0] id,
                            input logic [63:0] data, input bit rel, input bit clr);
    logic [7:0] rb [13];
    int len, nd, rl, hb;
    logic [3:0] code;
    logic [7:0] hinfo;
    rl = 0;
    if (rel && mmc > 0) begin
      hinfo = mmem[mrp];
      rl = (hinfo[7] ? 5 : 3) + (hinfo[6] ? 0 : int'(hinfo[3:0]));
    end
    code = (dlc > 4'd8) ? 4'd8 : dlc;
    nd   = rtr ? 0 : int'(code);
    for (int i = 0; i < 13; i++) rb[i] = 8'h00;
    rb[0] = {ext, rtr, 2'b00, code};
    if (ext) begin
      rb[1] = id[28:21]; rb[2] = id[20:13]; rb[3] = id[12:5]; rb[4] = {id[4:0], 3'b000};
      hb = 5;
    end else begin
      rb[1] = id[10:3]; rb[2] = {id[2:0], 5'b00000};
      hb = 3;
    end
    for (int i = 0; i < nd; i++) rb[hb + i] = data[8*i +: 8];
    len = hb + nd;
    if (wv && (mbc + len > 64)) movr = 1'b1;
    else if (clr) movr = 1'b0;
    if (wv && (mbc + len <= 64)) begin
      for (int i = 0; i < len; i++) mmem[(mwp + i) % 64] = rb[i];
      mwp = (mwp + len) % 64; mbc += len; mmc++;
    end
    if (rl > 0) begin
      mrp = (mrp + rl) % 64; mbc -= rl; mmc--;
    end
  endtask

  task automatic drive(input bit wv, input bit ext, input bit rtr,
                       input logic [3:0] dlc, input logic [28:0] id,
                       input logic [63:0] data, input bit rel, input bit clr);
    @(negedge clk);
    wr_valid = wv; wr_ext = ext; wr_rtr = rtr; wr_dlc = dlc; wr_id = id;
    wr_data = data; rel_cmd = rel; clr_ovr = clr;
    model_step(wv, ext, rtr, dlc, id, data, rel, clr);
    @(negedge clk);
    wr_valid = 1'b0; rel_cmd = 1'b0; clr_ovr = 1'b0;
  endtask

  task automatic rd(input int k, output logic [7:0] v);
    rd_off = 4'(k);
    #0.5;
    v = rd_byte;
  endtask

  task automatic check_model(input string tag);
    logic [7:0] v;
    chk({tag, " R4 byte_cnt"}, 64'(byte_cnt), 64'(mbc));
    chk({tag, " R7 msg_cnt"}, 64'(msg_cnt), 64'(mmc));
    chk({tag, " R6 ovr_flag"}, 64'(ovr_flag), 64'(movr));
    chk({tag, " R7 nonempty"}, 64'(nonempty), 64'(mmc != 0));
    for (int k = 0; k < 13 && k < mbc; k++) begin
      rd(k, v);
      chk({tag, " R9 window"}, 64'(v), 64'(mmem[(mrp + k) % 64]));
    end
  endtask

  // {op, ext, rtr, dlc, id, data, exp_bc, exp_mc, exp_ovr}; op 0 write, 1 release, 2 both
  localparam int NV = 18;
  localparam logic [113:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 4'd2,  29'h00005A3,  64'h0000000000002211, 7'd5,  5'd1, 1'b0},
    {2'd0, 1'b1, 1'b0, 4'd8,  29'h1ABCDEF1, 64'h8877665544332211, 7'd18, 5'd2, 1'b0},
    {2'd0, 1'b0, 1'b1, 4'd4,  29'h0000123,  64'hFFFFFFFFFFFFFFFF, 7'd21, 5'd3, 1'b0},
    {2'd0, 1'b1, 1'b0, 4'd12, 29'h00ABCDEF, 64'h0102030405060708, 7'd34, 5'd4, 1'b0},
    {2'd0, 1'b1, 1'b1, 4'd3,  29'h1FFFFFFF, 64'h000000000000DEAD, 7'd39, 5'd5, 1'b0},
    {2'd1, 1'b0, 1'b0, 4'd0,  29'h0000000,  64'h0,                7'd34, 5'd4, 1'b0},
    {2'd2, 1'b0, 1'b0, 4'd8,  29'h00007FF,  64'hA1A2A3A4A5A6A7A8, 7'd32, 5'd4, 1'b0},
    {2'd0, 1'b1, 1'b0, 4'd8,  29'h0000001,  64'h1111111111111111, 7'd45, 5'd5, 1'b0},
    {2'd0, 1'b1, 1'b0, 4'd8,  29'h10000000, 64'h2222222222222222, 7'd58, 5'd6, 1'b0},
    {2'd0, 1'b1, 1'b0, 4'd8,  29'h15555555, 64'h3333333333333333, 7'd58, 5'd6, 1'b1},
    {2'd0, 1'b0, 1'b0, 4'd3,  29'h0000001,  64'h0000000000C3C2C1, 7'd64, 5'd7, 1'b1},
    {2'd1, 1'b0, 1'b0, 4'd0,  29'h0000000,  64'h0,                7'd61, 5'd6, 1'b1},
    {2'd1, 1'b0, 1'b0, 4'd0,  29'h0000000,  64'h0,                7'd48, 5'd5, 1'b1},
    {2'd1, 1'b0, 1'b0, 4'd0,  29'h0000000,  64'h0,                7'd43, 5'd4, 1'b1},
    {2'd1, 1'b0, 1'b0, 4'd0,  29'h0000000,  64'h0,                7'd32, 5'd3, 1'b1},
    {2'd1, 1'b0, 1'b0, 4'd0,  29'h0000000,  64'h0,                7'd19, 5'd2, 1'b1},
    {2'd1, 1'b0, 1'b0, 4'd0,  29'h0000000,  64'h0,                7'd6,  5'd1, 1'b1},
    {2'd1, 1'b0, 1'b0, 4'd0,  29'h0000000,  64'h0,                7'd0,  5'd0, 1'b1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; wr_valid = 1'b0; wr_ext = 1'b0; wr_rtr = 1'b0; wr_dlc = '0;
    wr_id = '0; wr_data = '0; rel_cmd = 1'b0; clr_ovr = 1'b0; rd_off = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R12 reset byte_cnt", 64'(byte_cnt), 64'd0);
    chk("R12 reset msg_cnt", 64'(msg_cnt), 64'd0);
    chk("R12 reset ovr", 64'(ovr_flag), 64'd0);
    chk("R12 reset nonempty", 64'(nonempty), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk
    for (int n = 0; n < NV; n++) begin
      logic [113:0] e;
      e = VEC[n];
      drive(e[113:112] != 2'd1, e[111], e[110], e[109:106], e[105:77], e[76:13],
            e[113:112] != 2'd0, 1'b0);
      chk(e[113:112] == 2'd2 ? "R11 table byte_cnt" : "R4 table byte_cnt",
          64'(byte_cnt), 64'(e[12:6]));
      chk("R7 table msg_cnt", 64'(msg_cnt), 64'(e[5:1]));
      chk("R6 table ovr", 64'(ovr_flag), 64'(e[0]));
      check_model("table");
    end

    // R8: release on empty is ignored, then the next record starts at the same place
    drive(1'b0, 1'b0, 1'b0, 4'd0, 29'd0, 64'd0, 1'b1, 1'b0);
    chk("R8 empty release msg_cnt", 64'(msg_cnt), 64'd0);
    chk("R8 empty release byte_cnt", 64'(byte_cnt), 64'd0);
    drive(1'b1, 1'b0, 1'b0, 4'd1, 29'h7A5, 64'h5C, 1'b0, 1'b0);
    check_model("R8 after empty release");

    // R10: clear overrun
    drive(1'b0, 1'b0, 1'b0, 4'd0, 29'd0, 64'd0, 1'b0, 1'b1);
    chk("R10 clear ovr", 64'(ovr_flag), 64'd0);
    for (int i = 0; i < 4; i++)
      drive(1'b1, 1'b1, 1'b0, 4'd8, 29'(i * 1234567), 64'h0F0E0D0C0B0A0908, 1'b0, 1'b0);
    chk("R6 fill byte_cnt", 64'(byte_cnt), 64'd56);
    drive(1'b1, 1'b1, 1'b0, 4'd8, 29'h1, 64'h1, 1'b0, 1'b1);
    chk("R10 set wins over clear", 64'(ovr_flag), 64'd1);
    chk("R6 drop keeps byte_cnt", 64'(byte_cnt), 64'd56);
    check_model("R10 drop with clear");
    drive(1'b0, 1'b0, 1'b0, 4'd0, 29'd0, 64'd0, 1'b0, 1'b1);
    chk("R10 clear after drop", 64'(ovr_flag), 64'd0);

    // R12: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 mid reset byte_cnt", 64'(byte_cnt), 64'd0);
    chk("R12 mid reset msg_cnt", 64'(msg_cnt), 64'd0);
    chk("R12 mid reset nonempty", 64'(nonempty), 64'd0);
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: standard record layout
    drive(1'b1, 1'b0, 1'b0, 4'd2, 29'h5A3, 64'h2211, 1'b0, 1'b0);
    rd(0, v); chk("R1 std info", 64'(v), 64'h02);
    rd(1, v); chk("R3 std id hi", 64'(v), 64'hB4);
    rd(2, v); chk("R3 std id lo", 64'(v), 64'h60);
    rd(3, v); chk("R3 std data0", 64'(v), 64'h11);
    rd(4, v); chk("R3 std data1", 64'(v), 64'h22);
    chk("R4 std len", 64'(byte_cnt), 64'd5);
    drive(1'b0, 1'b0, 1'b0, 4'd0, 29'd0, 64'd0, 1'b1, 1'b0);

    // R2 / R5: extended record with clamped code
    drive(1'b1, 1'b1, 1'b0, 4'd12, 29'h1ABCDEF1, 64'h8877665544332211, 1'b0, 1'b0);
    rd(0, v);  chk("R5 clamped info", 64'(v), 64'h88);
    rd(1, v);  chk("R2 ext id 28:21", 64'(v), 64'hD5);
    rd(2, v);  chk("R2 ext id 20:13", 64'(v), 64'hE6);
    rd(3, v);  chk("R2 ext id 12:5", 64'(v), 64'hF7);
    rd(4, v);  chk("R2 ext id 4:0", 64'(v), 64'h88);
    rd(5, v);  chk("R2 ext data0", 64'(v), 64'h11);
    rd(12, v); chk("R5 ext data7", 64'(v), 64'h88);
    chk("R5 ext len", 64'(byte_cnt), 64'd13);

    // R4: remote frame stores no data
    drive(1'b1, 1'b0, 1'b1, 4'd4, 29'h123, 64'hFFFF, 1'b0, 1'b0);
    chk("R4 remote len", 64'(byte_cnt), 64'd16);
    drive(1'b0, 1'b0, 1'b0, 4'd0, 29'd0, 64'd0, 1'b1, 1'b0);
    rd(0, v); chk("R1 remote info", 64'(v), 64'h44);
    chk("R7 release ext byte_cnt", 64'(byte_cnt), 64'd3);

    // R9: offsets past the window read zero
    for (int k = 13; k < 16; k++) begin
      rd(k, v); chk("R9 out of window", 64'(v), 64'h00);
    end

    // R11: write and release in one cycle, then on an empty store
    drive(1'b1, 1'b0, 1'b0, 4'd1, 29'h0F0, 64'h99, 1'b1, 1'b0);
    chk("R11 swap msg_cnt", 64'(msg_cnt), 64'd1);
    chk("R11 swap byte_cnt", 64'(byte_cnt), 64'd4);
    drive(1'b0, 1'b0, 1'b0, 4'd0, 29'd0, 64'd0, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 4'd0, 29'h3FF, 64'h0, 1'b1, 1'b0);
    chk("R11 empty write+release msg_cnt", 64'(msg_cnt), 64'd1);
    chk("R11 empty write+release byte_cnt", 64'(byte_cnt), 64'd3);
    check_model("R11 final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule